// File: doc/BRIEF.md
# Integer Add/Subtract Execute Unit with Condition Flags

This unit decodes and executes the plain (no carry-in) integer add and subtract instructions of a 64-bit load/store instruction set. Three encoding classes are handled: a 12-bit immediate, a register operand passed through a constant shift, and a register operand passed through a zero-extend followed by a small left shift. Each instruction selects 32-bit or 64-bit operation, add or subtract, and whether the condition nibble is updated.

The surrounding pipeline presents a 32-bit instruction word with a valid strobe, together with the values read from the register file for the two source index fields and the current stack pointer. One clock later the unit reports the destination index, the write-back value with its enable, whether the write targets the stack pointer, whether the flag nibble was updated, the resulting flag nibble, and whether the word was an undefined encoding. The register file itself lives outside the unit. The unit keeps the condition nibble as its only architectural state.

Top module: `addsub_exec`

## Requirements
- R1: Immediate class (bits 28:24 = 10001): operand B is imm12 (bits 21:10), shifted left by 12 when bit 22 is 1. A value of 1 in bit 23 is undefined.
- R2: Shifted-register class (bits 28:24 = 01011, bit 21 = 0): operand B is Rm (bits 20:16) shifted by imm6 (bits 15:10) at the selected width; bits 23:22 select 00 logical left, 01 logical right, 10 arithmetic right. Type 11, or imm6 above 31 with bit 31 = 0, is undefined.
- R3: Extended-register class (bits 28:24 = 01011, bit 21 = 1): option (bits 15:13) 010 takes the low word of Rm zero-extended, 011 takes all of Rm; the value is then shifted left by imm3 (bits 12:10). imm3 above 4, any other option, or bits 23:22 not 00 is undefined.
- R4: Index 31 in Rn reads the stack pointer in the immediate and extended classes and zero in the shifted class. Index 31 in Rd (bits 4:0) writes the stack pointer only when bit 29 is 0 and the class is not shifted; otherwise the write is dropped. Index 31 in Rm always reads zero. The supplied register value is ignored whenever index 31 applies.
- R5: With bit 31 = 0, operands are taken at 32 bits and the write-back value is the low 32 bits of the result with the upper 32 bits zero.
- R6: C is the carry out of the selected width for add (bit 30 = 0); for subtract (bit 30 = 1) C is 1 when A is greater than or equal to B as unsigned numbers at that width.
- R7: The flag nibble is ordered N (bit 3), Z (bit 2), C (bit 1), V (bit 0): N is the result's top bit, Z marks a zero result, V marks signed overflow of the add or subtract, all at the selected width.
- R8: The flag nibble updates, with its enable raised, only for defined instructions with bit 29 = 1; otherwise it holds its value. It resets to 0000.
- R9: Any word outside the three classes is undefined. An undefined word raises the undefined flag and suppresses both the register write and the flag update.
- R10: All outputs are registered and appear one clock after the valid strobe, with the output valid high for exactly that one cycle; without a strobe no write, flag update or undefined report is produced. Reset clears all enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction word and operands are valid this cycle |
| insn | input | 32 | Instruction word |
| rn_data | input | 64 | Register-file value for the Rn index |
| rm_data | input | 64 | Register-file value for the Rm index |
| sp_data | input | 64 | Current stack pointer value |
| out_valid | output | 1 | Result of the previous cycle's instruction is present |
| undef | output | 1 | The instruction was an undefined encoding |
| wb_en | output | 1 | Write wb_data to the destination |
| wb_to_sp | output | 1 | The write targets the stack pointer rather than a general register |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Write-back value |
| flag_en | output | 1 | The flag nibble was updated by this instruction |
| nzcv | output | 4 | Current condition flags N, Z, C, V |

## Verification
The hardest situations to reach are those where index 31 meets the set-flags bit and the encoding class at once, and the reserved-encoding boundaries of 32-bit shifts (imm6 of exactly 32) and of the extend shift (imm3 of exactly 5). Random stimulus draws index 31 for each register field about one time in four, draws imm6 and imm3 across their full ranges, and picks operand values from a pool rich in all-ones, sign-boundary and upper-half-garbage patterns so that 32-bit carries and overflows occur often. Directed vectors pin the exact boundaries and the flag-hold case after a non-flag-setting instruction.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  localparam int XLEN    = 64;
  localparam int HALF    = XLEN / 2;
  localparam int INSNW   = 32;
  localparam int REGW    = 5;
  localparam int IMMW    = 12;
  localparam int IMMSH   = 12;
  localparam int SAMTW   = 6;
  localparam int EAMTW   = 3;
  localparam int EXT_MAX = 4;
  localparam int FLAGW   = 4;

  localparam int FLG_N = 3;
  localparam int FLG_Z = 2;
  localparam int FLG_C = 1;
  localparam int FLG_V = 0;

  localparam logic [REGW-1:0] REG31   = '1;
  localparam logic [4:0]      OPC_IMM = 5'b10001;
  localparam logic [4:0]      OPC_REG = 5'b01011;

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_IMM  = 2'd1,
    CLS_SHF  = 2'd2,
    CLS_EXT  = 2'd3
  } cls_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_RSV = 2'd3
  } shtyp_e;

  typedef struct packed {
    cls_e             cls;
    logic             wide;
    logic             sub;
    logic             setf;
    logic             undef;
    logic [REGW-1:0]  rd;
    logic [REGW-1:0]  rn;
    logic [REGW-1:0]  rm;
    shtyp_e           sh_typ;
    logic [SAMTW-1:0] sh_amt;
    logic             ext_full;
    logic [EAMTW-1:0] ext_amt;
    logic [IMMW-1:0]  imm12;
    logic             imm_hi;
  } dec_t;

  typedef struct packed {
    logic [XLEN-1:0]  val;
    logic [FLAGW-1:0] nzcv;
  } alu_t;

  // Constant shift of a register operand at the selected width.
  function automatic logic [XLEN-1:0] shift_op(input logic [XLEN-1:0]  v,
                                               input shtyp_e           typ,
                                               input logic [SAMTW-1:0] amt,
                                               input logic             wide);
    logic [HALF-1:0] w;
    logic [HALF-1:0] wr;
    logic [XLEN-1:0] r;
    w = v[HALF-1:0];
    if (wide) begin
      case (typ)
        SH_LSL:  r = v << amt;
        SH_LSR:  r = v >> amt;
        SH_ASR:  r = $signed(v) >>> amt;
        default: r = v;
      endcase
    end else begin
      case (typ)
        SH_LSL:  wr = w << amt[SAMTW-2:0];
        SH_LSR:  wr = w >> amt[SAMTW-2:0];
        SH_ASR:  wr = $signed(w) >>> amt[SAMTW-2:0];
        default: wr = w;
      endcase
      r = {{HALF{1'b0}}, wr};
    end
    return r;
  endfunction

  // Add or subtract with the condition nibble at the selected width.
  function automatic alu_t addsub_calc(input logic [XLEN-1:0] a,
                                       input logic [XLEN-1:0] b,
                                       input logic            sub,
                                       input logic            wide);
    logic [XLEN-1:0] bx;
    logic [XLEN:0]   s_w;
    logic [HALF:0]   s_n;
    logic [XLEN-1:0] ov;
    logic [XLEN-1:0] r;
    alu_t            o;
    bx  = sub ? ~b : b;
    s_w = {1'b0, a} + {1'b0, bx} + {{XLEN{1'b0}}, sub};
    s_n = {1'b0, a[HALF-1:0]} + {1'b0, bx[HALF-1:0]} + {{HALF{1'b0}}, sub};
    ov  = (s_w[XLEN-1:0] ^ a) & ~(a ^ bx);
    if (wide) begin
      r = s_w[XLEN-1:0];
      o.nzcv = {r[XLEN-1], (r == '0), s_w[XLEN], ov[XLEN-1]};
    end else begin
      r = {{HALF{1'b0}}, s_n[HALF-1:0]};
      o.nzcv = {r[HALF-1], (r == '0), s_n[HALF], ov[HALF-1]};
    end
    o.val = r;
    return o;
  endfunction

endpackage

// File: rtl/addsub_decode.sv
module addsub_decode
  import addsub_pkg::*;
(
  input  logic [INSNW-1:0] insn,
  output dec_t             dec
);

  logic [4:0] opc;
  logic       is_imm;
  logic       is_shf;
  logic       is_ext;

  assign opc    = insn[28:24];
  assign is_imm = (opc == OPC_IMM);
  assign is_shf = (opc == OPC_REG) && !insn[21];
  assign is_ext = (opc == OPC_REG) &&  insn[21];

  always_comb begin
    dec          = '0;
    dec.wide     = insn[31];
    dec.sub      = insn[30];
    dec.setf     = insn[29];
    dec.rd       = insn[4:0];
    dec.rn       = insn[9:5];
    dec.rm       = insn[20:16];
    dec.imm12    = insn[21:10];
    dec.imm_hi   = insn[22];
    dec.sh_typ   = shtyp_e'(insn[23:22]);
    dec.sh_amt   = insn[15:10];
    dec.ext_full = insn[13];
    dec.ext_amt  = insn[12:10];
    if (is_imm) begin
      dec.cls   = CLS_IMM;
      dec.undef = insn[23];
    end else if (is_shf) begin
      dec.cls   = CLS_SHF;
      dec.undef = (shtyp_e'(insn[23:22]) == SH_RSV) || (!insn[31] && insn[15]);
    end else if (is_ext) begin
      dec.cls   = CLS_EXT;
      dec.undef = (insn[23:22] != 2'b00) ||
                  (int'(insn[12:10]) > EXT_MAX) ||
                  (insn[15:14] != 2'b01);
    end else begin
      dec.cls   = CLS_NONE;
      dec.undef = 1'b1;
    end
  end

endmodule

// File: rtl/addsub_operands.sv
module addsub_operands
  import addsub_pkg::*;
(
  input  cls_e             cls,
  input  logic             wide,
  input  logic [REGW-1:0]  rn_idx,
  input  logic [REGW-1:0]  rm_idx,
  input  shtyp_e           sh_typ,
  input  logic [SAMTW-1:0] sh_amt,
  input  logic             ext_full,
  input  logic [EAMTW-1:0] ext_amt,
  input  logic [IMMW-1:0]  imm12,
  input  logic             imm_hi,
  input  logic [XLEN-1:0]  rn_data,
  input  logic [XLEN-1:0]  rm_data,
  input  logic [XLEN-1:0]  sp_data,
  output logic [XLEN-1:0]  op_a,
  output logic [XLEN-1:0]  op_b
);

  logic            rn_is_sp;
  logic            rn_is_zr;
  logic [XLEN-1:0] rm_v;
  logic [XLEN-1:0] ext_v;
  logic [XLEN-1:0] imm_v;

  assign rn_is_sp = (rn_idx == REG31) && (cls != CLS_SHF);
  assign rn_is_zr = (rn_idx == REG31) && (cls == CLS_SHF);

  always_comb begin
    if (rn_is_sp)      op_a = sp_data;
    else if (rn_is_zr) op_a = '0;
    else               op_a = rn_data;
  end

  assign rm_v  = (rm_idx == REG31) ? '0 : rm_data;
  assign ext_v = ext_full ? rm_v : {{HALF{1'b0}}, rm_v[HALF-1:0]};
  assign imm_v = imm_hi ? {{(XLEN-IMMW-IMMSH){1'b0}}, imm12, {IMMSH{1'b0}}}
                        : {{(XLEN-IMMW){1'b0}}, imm12};

  always_comb begin
    case (cls)
      CLS_IMM: op_b = imm_v;
      CLS_SHF: op_b = shift_op(rm_v, sh_typ, sh_amt, wide);
      CLS_EXT: op_b = ext_v << ext_amt;
      default: op_b = rm_v;
    endcase
  end

endmodule

// File: rtl/addsub_alu.sv
module addsub_alu
  import addsub_pkg::*;
(
  input  logic [XLEN-1:0]  op_a,
  input  logic [XLEN-1:0]  op_b,
  input  logic             sub,
  input  logic             wide,
  output logic [XLEN-1:0]  res,
  output logic [FLAGW-1:0] nzcv
);

  alu_t calc;

  assign calc = addsub_calc(op_a, op_b, sub, wide);
  assign res  = calc.val;
  assign nzcv = calc.nzcv;

endmodule

// File: rtl/addsub_exec.sv
module addsub_exec
  import addsub_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [31:0]      insn,
  input  logic [63:0]      rn_data,
  input  logic [63:0]      rm_data,
  input  logic [63:0]      sp_data,
  output logic             out_valid,
  output logic             undef,
  output logic             wb_en,
  output logic             wb_to_sp,
  output logic [4:0]       wb_idx,
  output logic [63:0]      wb_data,
  output logic             flag_en,
  output logic [3:0]       nzcv
);

  dec_t             dec;
  logic [XLEN-1:0]  op_a;
  logic [XLEN-1:0]  op_b;
  logic [XLEN-1:0]  alu_res;
  logic [FLAGW-1:0] alu_nzcv;

  // Named internal events used by the assertions.
  logic rd_is31;
  logic ev_wr_sp;
  logic ev_wr_en;
  logic ev_fl_en;
  logic wide_q;

  addsub_decode u_dec (
    .insn (insn),
    .dec  (dec)
  );

  addsub_operands u_ops (
    .cls      (dec.cls),
    .wide     (dec.wide),
    .rn_idx   (dec.rn),
    .rm_idx   (dec.rm),
    .sh_typ   (dec.sh_typ),
    .sh_amt   (dec.sh_amt),
    .ext_full (dec.ext_full),
    .ext_amt  (dec.ext_amt),
    .imm12    (dec.imm12),
    .imm_hi   (dec.imm_hi),
    .rn_data  (rn_data),
    .rm_data  (rm_data),
    .sp_data  (sp_data),
    .op_a     (op_a),
    .op_b     (op_b)
  );

  addsub_alu u_alu (
    .op_a (op_a),
    .op_b (op_b),
    .sub  (dec.sub),
    .wide (dec.wide),
    .res  (alu_res),
    .nzcv (alu_nzcv)
  );

  assign rd_is31  = (dec.rd == REG31);
  assign ev_wr_sp = rd_is31 && !dec.setf && (dec.cls != CLS_SHF) && !dec.undef;
  assign ev_wr_en = !dec.undef && (!rd_is31 || ev_wr_sp);
  assign ev_fl_en = !dec.undef && dec.setf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      undef     <= 1'b0;
      wb_en     <= 1'b0;
      wb_to_sp  <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      flag_en   <= 1'b0;
      nzcv      <= '0;
      wide_q    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      undef     <= in_valid && dec.undef;
      wb_en     <= in_valid && ev_wr_en;
      wb_to_sp  <= in_valid && ev_wr_sp;
      flag_en   <= in_valid && ev_fl_en;
      if (in_valid) begin
        wb_idx  <= dec.rd;
        wb_data <= alu_res;
        wide_q  <= dec.wide;
      end
      if (in_valid && ev_fl_en) begin
        nzcv <= alu_nzcv;
      end
    end
  end

  AST_UNDEF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> (!wb_en && !flag_en)); // R9

  AST_NZCV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_en |-> $stable(nzcv)); // R8

  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !wide_q) |-> (wb_data[XLEN-1:HALF] == '0)); // R5

  AST_SP_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wb_to_sp |-> (wb_en && !flag_en && (wb_idx == REG31))); // R4

  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en || flag_en || undef) |-> out_valid); // R10

  AST_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec.sub && dec.wide) |-> (alu_nzcv[FLG_C] == (op_a >= op_b))); // R6

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (alu_nzcv[FLG_Z] == (alu_res == '0))); // R7

endmodule

// File: tb/addsub_exec_test.sv
`timescale 1ns/1ps
module addsub_exec_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] rn_data = '0;
  logic [63:0] rm_data = '0;
  logic [63:0] sp_data = '0;
  logic        out_valid, undef, wb_en, wb_to_sp, flag_en;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;
  logic [3:0]  nzcv;

  addsub_exec uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
    .rn_data(rn_data), .rm_data(rm_data), .sp_data(sp_data),
    .out_valid(out_valid), .undef(undef), .wb_en(wb_en), .wb_to_sp(wb_to_sp),
    .wb_idx(wb_idx), .wb_data(wb_data), .flag_en(flag_en), .nzcv(nzcv)
  );

  always #4 clk = ~clk;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;
  logic [3:0]  m_nzcv = 4'h0;
  logic        e_undef, e_wb_en, e_sp, e_flag_en;
  logic [4:0]  e_idx;
  logic [63:0] e_data;
  logic [3:0]  e_nzcv_new;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_imm(input bit sf, op, s, input logic [1:0] sh,
                                         input logic [11:0] imm, input logic [4:0] rn, rd);
    return {sf, op, s, 5'b10001, sh, imm, rn, rd};
  endfunction

  function automatic logic [31:0] mk_shf(input bit sf, op, s, input logic [1:0] typ, input logic [4:0] rm,
                                         input logic [5:0] amt, input logic [4:0] rn, rd);
    return {sf, op, s, 5'b01011, typ, 1'b0, rm, amt, rn, rd};
  endfunction

  function automatic logic [31:0] mk_ext(input bit sf, op, s, input logic [1:0] hi, input logic [4:0] rm,
                                         input logic [2:0] opt, input logic [2:0] amt,
                                         input logic [4:0] rn, rd);
    return {sf, op, s, 5'b01011, hi, 1'b1, rm, opt, amt, rn, rd};
  endfunction

  // Reference model written from the requirements.
  function automatic void model(input logic [31:0] iw, input logic [63:0] rnv, rmv, spv);
    logic sf, op, s, is_imm, is_reg, is_shf, is_ext, c, v;
    logic [63:0] a, b, r, rmx;
    logic [31:0] a32, b32, r32;
    logic [1:0]  typ;
    int amt;
    sf = iw[31]; op = iw[30]; s = iw[29];
    is_imm = (iw[28:24] == 5'b10001);
    is_reg = (iw[28:24] == 5'b01011);
    is_shf = is_reg && !iw[21];
    is_ext = is_reg && iw[21];
    typ = iw[23:22];
    amt = is_shf ? int'(iw[15:10]) : int'(iw[12:10]);
    e_undef = !(is_imm || is_reg);
    if (is_imm && iw[23]) e_undef = 1'b1;
    if (is_shf && (typ == 2'd3 || (!sf && amt > 31))) e_undef = 1'b1;
    if (is_ext && (typ != 2'd0 || amt > 4 || !(iw[15:13] == 3'd2 || iw[15:13] == 3'd3))) e_undef = 1'b1;
    a   = (iw[9:5] == 5'd31) ? (is_shf ? 64'd0 : spv) : rnv;
    rmx = (iw[20:16] == 5'd31) ? 64'd0 : rmv;
    if (is_imm) begin
      b = iw[22] ? {40'd0, iw[21:10], 12'd0} : {52'd0, iw[21:10]};
    end else if (is_shf) begin
      if (sf) begin
        case (typ)
          2'd0:    b = rmx << amt;
          2'd1:    b = rmx >> amt;
          default: b = (rmx >> amt) | (rmx[63] ? ~(64'hFFFF_FFFF_FFFF_FFFF >> amt) : 64'd0);
        endcase
      end else begin
        b32 = rmx[31:0];
        case (typ)
          2'd0:    b32 = b32 << amt;
          2'd1:    b32 = b32 >> amt;
          default: b32 = (b32 >> amt) | (b32[31] ? ~(32'hFFFF_FFFF >> amt) : 32'd0);
        endcase
        b = {32'd0, b32};
      end
    end else begin
      b = (iw[13] ? rmx : {32'd0, rmx[31:0]}) << amt;
    end
    if (sf) begin
      r = op ? a - b : a + b;
      c = op ? (a >= b) : (r < a);
      v = op ? (a[63] != b[63] && r[63] != a[63]) : (a[63] == b[63] && r[63] != a[63]);
      e_nzcv_new = {r[63], r == 64'd0, c, v};
    end else begin
      a32 = a[31:0]; b32 = b[31:0];
      r32 = op ? a32 - b32 : a32 + b32;
      c = op ? (a32 >= b32) : (r32 < a32);
      v = op ? (a32[31] != b32[31] && r32[31] != a32[31]) : (a32[31] == b32[31] && r32[31] != a32[31]);
      e_nzcv_new = {r32[31], r32 == 32'd0, c, v};
      r = {32'd0, r32};
    end
    e_data    = r;
    e_idx     = iw[4:0];
    e_sp      = (iw[4:0] == 5'd31) && !s && !is_shf;
    e_wb_en   = !e_undef && (iw[4:0] != 5'd31 || e_sp);
    e_flag_en = !e_undef && s;
  endfunction

  task automatic apply(input logic [31:0] iw, input logic [63:0] rnv, rmv, spv, input string req);
    model(iw, rnv, rmv, spv);
    @(negedge clk);
    insn = iw; rn_data = rnv; rm_data = rmv; sp_data = spv; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, {req, " R10 out_valid"}, 64'(out_valid), 64'd1);
    chk(undef === e_undef, {req, " R9 undef"}, 64'(undef), 64'(e_undef));
    chk(wb_en === e_wb_en, {req, " R9 wb_en"}, 64'(wb_en), 64'(e_wb_en));
    chk(flag_en === e_flag_en, {req, " R8 flag_en"}, 64'(flag_en), 64'(e_flag_en));
    if (e_flag_en) m_nzcv = e_nzcv_new;
    chk(nzcv === m_nzcv, {req, " R7 nzcv"}, 64'(nzcv), 64'(m_nzcv));
    if (e_wb_en) begin
      chk(wb_to_sp === e_sp, {req, " R4 wb_to_sp"}, 64'(wb_to_sp), 64'(e_sp));
      chk(wb_idx === e_idx, {req, " wb_idx"}, 64'(wb_idx), 64'(e_idx));
      chk(wb_data === e_data, {req, " wb_data"}, wb_data, e_data);
    end
  endtask

  function automatic logic [63:0] rval();
    case ($urandom % 8)
      0:       return 64'd0;
      1:       return 64'hFFFF_FFFF_FFFF_FFFF;
      2:       return 64'h7FFF_FFFF_FFFF_FFFF;
      3:       return 64'h8000_0000_0000_0000;
      4:       return {32'($urandom), 32'hFFFF_FFFF};
      5:       return {32'($urandom), 32'h8000_0000};
      default: return {32'($urandom), 32'($urandom)};
    endcase
  endfunction

  function automatic logic [4:0] ridx();
    return ($urandom % 4 == 0) ? 5'd31 : 5'($urandom);
  endfunction

  initial begin
    logic [63:0] g;
    void'($urandom(32'd7341));
    g = 64'hA5A5_0000_0000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: R10, R8
    chk(out_valid === 1'b0 && wb_en === 1'b0 && flag_en === 1'b0 && undef === 1'b0,
        "R10 reset enables", {60'd0, out_valid, wb_en, flag_en, undef}, 64'd0);
    chk(nzcv === 4'h0, "R8 reset nzcv", 64'(nzcv), 64'd0);

    // Directed corner cases
    apply(mk_imm(1, 0, 0, 2'b01, 12'h123, 5'd4, 5'd3), 64'd10, g, 64'd0, "R1 imm lsl12");
    apply(mk_imm(1, 1, 1, 2'b10, 12'h001, 5'd4, 5'd3), 64'd10, g, 64'd0, "R1 R9 imm shift10");
    apply(mk_shf(1, 0, 1, 2'b10, 5'd5, 6'd63, 5'd6, 5'd7), 64'd1, 64'h8000_0000_0000_0000, 0, "R2 asr63");
    apply(mk_shf(0, 0, 0, 2'b00, 5'd5, 6'd32, 5'd6, 5'd7), 64'd1, 64'd1, 0, "R2 narrow imm6 32");
    apply(mk_shf(0, 0, 0, 2'b01, 5'd5, 6'd31, 5'd6, 5'd7), g, 64'hFFFF_FFFF_8000_0000, 0, "R2 narrow lsr31");
    apply(mk_shf(1, 0, 0, 2'b11, 5'd5, 6'd1, 5'd6, 5'd7), 64'd1, 64'd1, 0, "R2 type11");
    apply(mk_ext(1, 0, 0, 2'b00, 5'd8, 3'b010, 3'd4, 5'd9, 5'd2), 64'd3, 64'hDEAD_BEEF_0000_0001, 0, "R3 uxtw lsl4");
    apply(mk_ext(1, 0, 0, 2'b00, 5'd8, 3'b011, 3'd5, 5'd9, 5'd2), 64'd3, 64'd1, 0, "R3 imm3 5");
    apply(mk_ext(1, 0, 0, 2'b00, 5'd8, 3'b000, 3'd0, 5'd9, 5'd2), 64'd3, 64'd1, 0, "R3 option000");
    apply(mk_ext(1, 0, 0, 2'b01, 5'd8, 3'b011, 3'd0, 5'd9, 5'd2), 64'd3, 64'd1, 0, "R3 hi01");
    apply(mk_imm(1, 1, 0, 2'b00, 12'h010, 5'd31, 5'd31), 64'd999, g, 64'h1000, "R4 sp to sp");
    apply(mk_imm(1, 0, 1, 2'b00, 12'h001, 5'd31, 5'd31), 64'd999, g, 64'h1000, "R4 flags rd zr");
    apply(mk_shf(1, 0, 0, 2'b00, 5'd31, 6'd0, 5'd31, 5'd31), 64'd77, 64'd55, 64'h1000, "R4 shifted zr");
    apply(mk_ext(1, 0, 0, 2'b00, 5'd31, 3'b011, 3'd0, 5'd31, 5'd31), 64'd77, 64'd55, 64'h2000, "R4 ext rm zr");
    apply(mk_shf(1, 1, 1, 2'b00, 5'd2, 6'd0, 5'd1, 5'd3), 64'h1234, 64'h1234, 0, "R6 R7 sub equal");
    apply(mk_imm(0, 0, 1, 2'b00, 12'h001, 5'd1, 5'd3), 64'hFFFF_FFFF_7FFF_FFFF, g, 0, "R5 R7 narrow ovf");
    apply(mk_imm(1, 0, 1, 2'b00, 12'h001, 5'd1, 5'd3), 64'hFFFF_FFFF_FFFF_FFFF, g, 0, "R6 wide carry");
    apply(mk_imm(0, 1, 1, 2'b00, 12'h002, 5'd1, 5'd3), 64'hFFFF_0000_0000_0001, g, 0, "R6 narrow borrow");
    apply(mk_imm(1, 0, 0, 2'b00, 12'h005, 5'd1, 5'd3), 64'd0, g, 0, "R8 hold after no-S");
    apply(32'h0000_0000, 64'd1, 64'd1, 0, "R9 unknown class");

    // Idle cycle: no strobe, no activity (R10)
    @(negedge clk);
    chk(out_valid === 1'b0 && wb_en === 1'b0 && flag_en === 1'b0 && undef === 1'b0,
        "R10 idle", {60'd0, out_valid, wb_en, flag_en, undef}, 64'd0);

    // Constrained random
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] iw;
      string tag;
      bit sf, op, s;
      sf = 1'($urandom); op = 1'($urandom); s = 1'($urandom);
      case ($urandom % 4)
        0: begin
          iw = mk_imm(sf, op, s, ($urandom % 6 == 0) ? 2'($urandom) : {1'b0, 1'($urandom)},
                      12'($urandom), ridx(), ridx());
          tag = "R1 rnd";
        end
        1: begin
          iw = mk_shf(sf, op, s, ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3), ridx(),
                      6'($urandom), ridx(), ridx());
          tag = "R2 rnd";
        end
        2: begin
          iw = mk_ext(sf, op, s, ($urandom % 8 == 0) ? 2'($urandom) : 2'b00, ridx(),
                      ($urandom % 5 == 0) ? 3'($urandom) : {2'b01, 1'($urandom)},
                      3'($urandom), ridx(), ridx());
          tag = "R3 rnd";
        end
        default: begin
          iw = 32'($urandom);
          tag = "R9 rnd";
        end
      endcase
      apply(iw, rval(), rval(), rval(), tag);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R10: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule